// File: doc/BRIEF.md
# Raster Timing Generator with Phase Interrupts

This block produces the line and frame timing for a display pipe. Each line is walked through four horizontal phases (sync, back porch, active, front porch), and each frame is walked line by line through the same four vertical phases. From its phase counters the block drives active-high horizontal sync, vertical sync and data-enable strobes. It also drives a field flag, which is used for interlaced output.

Software programs the block through a small word-addressed register port. The port holds the phase lengths, the enables, the interrupt mask, and a sticky status word with one bit per timing event. Each frame can run once, or frames can repeat without a gap. When interlace is on, odd and even fields alternate, and the even field takes its vertical lengths from a second pair of words. The start of output can be held off until an external line-start pulse arrives.

Register words by index: 0 main control, 1 video control, 2 horizontal word A, 3 horizontal word B, 4 vertical word A, 5 vertical word B, 6 even-field vertical word A, 7 even-field vertical word B, 8 interrupt mask, 9 status. In every A word, sync length sits in bits 15:0 and back porch in bits 31:16. In every B word, active length sits in bits 15:0 and front porch in bits 31:16. Writes take effect at the clock edge. Reads are combinational.

Top module: `raster_timer`

## Requirements
- R1: With word 0 bit 0 and word 1 bit 0 set, the generator starts on the next clock edge. Each line then runs sync, back porch, active and front porch for the lengths held in words 2 and 3 (A: sync in 15:0, back porch in 31:16; B: active in 15:0, front porch in 31:16). hsyncOut is high exactly during the horizontal sync phase.
- R2: Vertical phases advance one step per line count, in the same order, with lengths taken from words 4 and 5. vsyncOut is high for every cycle of the vertical sync lines. Clearing word 1 bit 0 while the generator is running drops all three strobes within two cycles.
- R3: deOut is high only when the horizontal phase and the vertical phase are both active.
- R4: A phase length of zero removes that phase from the sequence, and its start event (status bit) is not raised.
- R5: When word 1 bit 1 (continuous) is clear, the generator stops after the last line of one frame. It sets status bit 8 (vertical front porch end) and bit 9 (video idle), and it holds all strobes low until video enable is cleared and set again.
- R6: Status word 9 sets a sticky bit at the start of each phase: bit 0 hsync, bit 1 h back porch, bit 2 h active, bit 3 h front porch, bit 4 vsync, bit 5 v back porch, bit 6 v active, bit 7 v front porch. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R7: irqOut is high exactly when some status bit is set and its mask bit in word 8 is also set.
- R8: With word 1 bit 1 set, each frame is followed directly by the next frame, with no idle cycle in between.
- R9: With word 1 bit 4 (interlace) set as well, frames alternate between odd and even fields, starting with odd. Even fields use words 6 and 7. evenFieldOut is high during even fields.
- R10: With word 0 bit 12 set, the start waits for a cycle in which lineStartIn is high, and output begins on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| lineStartIn | input | 1 | External line-start pulse used when start gating is on |
| hsyncOut | output | 1 | Horizontal sync, active high |
| vsyncOut | output | 1 | Vertical sync, active high |
| deOut | output | 1 | Data enable, active high |
| evenFieldOut | output | 1 | High while the current field is the even field |
| irqOut | output | 1 | Masked interrupt request |

## Verification
The strobes are compared cycle by cycle against a frame built by the bench from the programmed lengths, using four timing patterns:
- Plain single frame: fixes the phase order and the stop point.
- Zero-length back porches: separates skipping a phase from running it for zero cycles.
- Three interlaced continuous frames with different even-field lengths: exposes field alternation, wrong timing-word selection and any gap between frames.
- Gated start held off by lineStartIn: exposes early starts.

Status snapshots after the single and skipped runs show which phase events fired. Clear and mask writes then isolate the sticky, write-one-to-clear and interrupt-masking behaviour.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int LEN_W  = 16;
  localparam int NUM_EV = 10;
  localparam int EV_VFP_END = 8;
  localparam int EV_IDLE    = 9;

  typedef logic [3:0][LEN_W-1:0] lens_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic continuous;
    logic interlace;
  } vtg_strobe_t;

  typedef struct packed {
    lens_t h;
    lens_t vOdd;
    lens_t vEven;
  } vtg_timing_t;

  // next phase after cur whose length is nonzero, scanning in order with wrap
  function automatic logic [1:0] nextPhase(input lens_t len, input logic [1:0] cur);
    logic [1:0] res;
    logic found;
    res = cur;
    found = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      logic [1:0] idx;
      idx = cur + 2'(k);
      if (!found && len[idx] != '0) begin
        res = idx;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic anyLen(input lens_t len);
    return (len[0] | len[1] | len[2] | len[3]) != '0;
  endfunction
endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wrData,
  output logic [DW-1:0]     rdData,
  input  logic              lineStartIn,
  input  logic              running,
  input  logic [NUM_EV-1:0] events,
  output logic [NUM_EV-1:0] statOut,
  output logic              irq,
  output vtg_strobe_t       strobe,
  output vtg_timing_t       timing
);
  localparam int NUM_REGS = 9;
  localparam int STAT_IDX = 9;
  localparam int MASK_IDX = 8;

  logic [DW-1:0]     regBank [NUM_REGS];
  logic [NUM_EV-1:0] stat;
  logic              doneLatch;
  logic              enAll, waitH, goNow;
  logic              statWr;

  assign statWr = wrEn && (addr == ADDR_W'(STAT_IDX));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regBank[i] <= '0;
    end else if (wrEn && (addr < ADDR_W'(NUM_REGS))) begin
      regBank[addr] <= wrData;
    end
  end

  // event sets win over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rstN) stat <= '0;
    else stat <= (stat & ~(statWr ? wrData[NUM_EV-1:0] : '0)) | events;
  end

  assign enAll = regBank[0][0] && regBank[1][0];
  assign waitH = regBank[0][12];

  always_ff @(posedge clk) begin
    if (!rstN) doneLatch <= 1'b0;
    else if (!enAll) doneLatch <= 1'b0;
    else if (events[EV_IDLE]) doneLatch <= 1'b1;
  end

  always_comb begin
    timing.h     = {regBank[3][31:16], regBank[3][15:0], regBank[2][31:16], regBank[2][15:0]};
    timing.vOdd  = {regBank[5][31:16], regBank[5][15:0], regBank[4][31:16], regBank[4][15:0]};
    timing.vEven = {regBank[7][31:16], regBank[7][15:0], regBank[6][31:16], regBank[6][15:0]};
    goNow = enAll && !running && !doneLatch && anyLen(timing.h) && anyLen(timing.vOdd)
            && (!waitH || lineStartIn);
    strobe.start      = goNow;
    strobe.stop       = running && !enAll;
    strobe.continuous = regBank[1][1];
    strobe.interlace  = regBank[1][4];
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(STAT_IDX)) rdData = DW'(stat);
    else if (addr < ADDR_W'(NUM_REGS)) rdData = regBank[addr];
  end

  assign statOut = stat;
  assign irq     = |(stat & regBank[MASK_IDX][NUM_EV-1:0]);
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  vtg_strobe_t       strobe,
  input  vtg_timing_t       timing,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              evenField,
  output logic              running,
  output logic [NUM_EV-1:0] events
);
  logic [1:0]       hPh, vPh, hNxt, vNxt, hFirst;
  logic [LEN_W-1:0] hCnt, vCnt;
  lens_t            vLen, vNext;
  logic             hEnd, lineEnd, vEnd, frameEnd, newField, lineFirst;

  always_comb begin
    vLen      = (evenField && strobe.interlace) ? timing.vEven : timing.vOdd;
    hFirst    = nextPhase(timing.h, 2'd3);
    hNxt      = nextPhase(timing.h, hPh);
    vNxt      = nextPhase(vLen, vPh);
    hEnd      = running && (hCnt == timing.h[hPh] - LEN_W'(1));
    lineEnd   = hEnd && (hNxt <= hPh);
    vEnd      = lineEnd && (vCnt == vLen[vPh] - LEN_W'(1));
    frameEnd  = vEnd && (vNxt <= vPh);
    newField  = strobe.interlace ? !evenField : 1'b0;
    vNext     = newField ? timing.vEven : timing.vOdd;
    lineFirst = running && (hCnt == '0) && (hPh == hFirst);
  end

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_ev
      assign events[gi]     = running && (hCnt == '0) && (hPh == 2'(gi));
      assign events[4 + gi] = lineFirst && (vCnt == '0) && (vPh == 2'(gi));
    end
  endgenerate
  assign events[EV_VFP_END] = frameEnd;
  assign events[EV_IDLE]    = frameEnd && !strobe.continuous;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      hPh       <= '0;
      vPh       <= '0;
      hCnt      <= '0;
      vCnt      <= '0;
      evenField <= 1'b0;
    end else if (strobe.stop) begin
      running <= 1'b0;
    end else if (!running) begin
      if (strobe.start) begin
        running   <= 1'b1;
        hPh       <= hFirst;
        hCnt      <= '0;
        vPh       <= nextPhase(timing.vOdd, 2'd3);
        vCnt      <= '0;
        evenField <= 1'b0;
      end
    end else begin
      if (hEnd) begin
        hCnt <= '0;
        hPh  <= hNxt;
      end else begin
        hCnt <= hCnt + LEN_W'(1);
      end
      if (lineEnd) begin
        if (vEnd) begin
          vCnt <= '0;
          if (frameEnd) begin
            if (!strobe.continuous) running <= 1'b0;
            evenField <= newField;
            vPh       <= nextPhase(vNext, 2'd3);
          end else begin
            vPh <= vNxt;
          end
        end else begin
          vCnt <= vCnt + LEN_W'(1);
        end
      end
    end
  end

  assign hsyncOut = running && (hPh == 2'd0);
  assign vsyncOut = running && (vPh == 2'd0);
  assign deOut    = running && (hPh == 2'd2) && (vPh == 2'd2);
endmodule

// File: rtl/raster_timer.sv
module raster_timer
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              lineStartIn,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              deOut,
  output logic              evenFieldOut,
  output logic              irqOut
);
  vtg_strobe_t       strobe;
  vtg_timing_t       timing;
  logic              running;
  logic [NUM_EV-1:0] events;
  logic [NUM_EV-1:0] statBus;

  vtg_ctrl #(.ADDR_W(ADDR_W), .DW(32)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .rdData(regRdData), .lineStartIn(lineStartIn), .running(running), .events(events),
    .statOut(statBus), .irq(irqOut), .strobe(strobe), .timing(timing)
  );

  vtg_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timing(timing),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .deOut(deOut),
    .evenField(evenFieldOut), .running(running), .events(events)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hsync,
  input logic       vsync,
  input logic       de,
  input logic       irq,
  input logic [9:0] stat,
  input logic       statWr,
  input logic       start,
  input logic       running
);
  // R3
  de_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    de |-> (!hsync && !vsync));

  // R6
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statWr |=> ((stat & $past(stat)) == $past(stat)));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (stat != '0));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat[9]) |-> (!hsync && !vsync && !de));

  // R10
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !start) |=> !running);
endmodule

bind raster_timer vtg_checker u_chk (
  .clk(clk), .rstN(rstN), .hsync(hsyncOut), .vsync(vsyncOut), .de(deOut),
  .irq(irqOut), .stat(statBus), .statWr(regWrEn && (regAddr == 4'd9)),
  .start(strobe.start), .running(running)
);

// File: tb/raster_timer_bench.sv
module raster_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        lineStartIn = 1'b0;
  logic        hsyncOut, vsyncOut, deOut, evenFieldOut, irqOut;

  int checks = 0;
  int errs = 0;
  logic monOn = 1'b0;
  string curReq = "R1";
  logic [3:0] expQ[$];

  always #2 clk = ~clk;

  raster_timer u_raster_timer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .lineStartIn(lineStartIn), .hsyncOut(hsyncOut), .vsyncOut(vsyncOut),
    .deOut(deOut), .evenFieldOut(evenFieldOut), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // driver: push expected {evenField, de, vsync, hsync} for one frame
  task automatic pushFrame(input int h[4], input int v[4], input logic even);
    for (int vp = 0; vp < 4; vp++)
      for (int ln = 0; ln < v[vp]; ln++)
        for (int hp = 0; hp < 4; hp++)
          for (int c = 0; c < h[hp]; c++)
            expQ.push_back({even, (hp == 2 && vp == 2), (vp == 0), (hp == 0)});
  endtask

  task automatic drain();
    while (expQ.size() > 0) @(negedge clk);
    monOn = 1'b0;
  endtask

  // monitor: pop and compare once per cycle
  always @(negedge clk) begin
    if (monOn && expQ.size() > 0) begin
      logic [3:0] e;
      e = expQ.pop_front();
      check(curReq, {28'd0, evenFieldOut, deOut, vsyncOut, hsyncOut}, {28'd0, e});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int h[4];
    int v[4];
    int ve[4];
    h = '{2, 1, 4, 1};
    v = '{1, 1, 2, 1};
    ve = '{1, 2, 3, 1};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("R5 reset", {29'd0, hsyncOut, vsyncOut, deOut}, 32'd0);
    rd(4'd9, d); check("R6 reset", d, 32'd0);
    check("R7 reset", {31'd0, irqOut}, 32'd0);

    // single frame, plain lengths (R1 R2 R3 R5)
    wr(4'd2, {16'd1, 16'd2});
    wr(4'd3, {16'd1, 16'd4});
    wr(4'd4, {16'd1, 16'd1});
    wr(4'd5, {16'd1, 16'd2});
    wr(4'd0, 32'h1);
    curReq = "R1";
    pushFrame(h, v, 1'b0);
    wr(4'd1, 32'h1);
    @(posedge clk); monOn = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    check("R5 idle after frame", {29'd0, hsyncOut, vsyncOut, deOut}, 32'd0);
    rd(4'd9, d); check("R6 all events", d, 32'h3FF);
    repeat (20) @(negedge clk);
    check("R5 stays idle", {29'd0, hsyncOut, vsyncOut, deOut}, 32'd0);

    // W1C and masking (R6 R7)
    wr(4'd9, 32'h00F);
    rd(4'd9, d); check("R6 w1c", d, 32'h3F0);
    check("R7 masked off", {31'd0, irqOut}, 32'd0);
    wr(4'd8, 32'h200);
    check("R7 mask on", {31'd0, irqOut}, 32'd1);
    wr(4'd9, 32'h200);
    check("R7 cleared", {31'd0, irqOut}, 32'd0);
    rd(4'd9, d); check("R6 w1c keep", d, 32'h1F0);
    wr(4'd9, 32'h3FF);
    wr(4'd8, 32'h0);

    // zero-length back porches (R4)
    wr(4'd1, 32'h0);
    wr(4'd2, {16'd0, 16'd2});
    wr(4'd4, {16'd0, 16'd1});
    h = '{2, 0, 4, 1};
    v = '{1, 0, 2, 1};
    curReq = "R4";
    pushFrame(h, v, 1'b0);
    wr(4'd1, 32'h1);
    @(posedge clk); monOn = 1'b1;
    drain();
    repeat (3) @(negedge clk);
    rd(4'd9, d); check("R4 skipped events", d, 32'h3DD);
    wr(4'd9, 32'h3FF);

    // interlaced continuous (R8 R9), then disable (R2)
    wr(4'd1, 32'h0);
    wr(4'd2, {16'd1, 16'd2});
    wr(4'd4, {16'd1, 16'd1});
    wr(4'd6, {16'd2, 16'd1});
    wr(4'd7, {16'd1, 16'd3});
    h = '{2, 1, 4, 1};
    v = '{1, 1, 2, 1};
    curReq = "R9";
    pushFrame(h, v, 1'b0);
    pushFrame(h, ve, 1'b1);
    pushFrame(h, v, 1'b0);
    wr(4'd1, 32'h13);
    @(posedge clk); monOn = 1'b1;
    drain();
    rd(4'd9, d); check("R8 no idle event", {31'd0, d[9]}, 32'd0);
    wr(4'd1, 32'h0);
    repeat (2) @(negedge clk);
    check("R2 disable stops", {29'd0, hsyncOut, vsyncOut, deOut}, 32'd0);
    wr(4'd9, 32'h3FF);

    // gated start (R10)
    wr(4'd0, 32'h1001);
    wr(4'd1, 32'h1);
    repeat (6) @(negedge clk);
    check("R10 held", {29'd0, hsyncOut, vsyncOut, deOut}, 32'd0);
    rd(4'd9, d); check("R10 no events", d, 32'd0);
    curReq = "R10";
    pushFrame(h, v, 1'b0);
    lineStartIn = 1'b1;
    @(posedge clk); monOn = 1'b1;
    @(negedge clk); lineStartIn = 1'b0;
    drain();
    repeat (3) @(negedge clk);
    check("R10 done", {29'd0, hsyncOut, vsyncOut, deOut}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule